// File: doc/BRIEF.md
# Double-Buffer Transfer Control Sequencer

This block holds, for each of several transfer channels, the buffer selection of a double-buffered control packet and a count of the frames left in the active buffer. A two-bit enable value per channel says whether the channel is idle, working from buffer A, or working from buffer B. Each completed frame counts the active buffer down. When the frame that carries a count of one completes, the block decides whether the channel goes idle, repeats the same buffer, or moves to the other buffer.

That end-of-buffer decision normally follows a per-channel mode. Software may also write the enable value at any time through a simple register write port. A write made while the buffer still has frames left takes effect at once. A write made during the last frame is held until that frame completes, and is then weighed against the mode by a fixed three-way priority rule. The block only moves control state. The data transfer is outside it.

Top module: `pkt_buf_sequencer`

## Requirements
- R1: After reset every channel's enable value is 00 (idle) and its frame count is 0. Enable encoding: 00 idle, 01 buffer A, 10 buffer B, 11 means "no change".
- R2: A write of 01 or 10 to an idle channel activates it on the next cycle and loads the frame count from cfgFrames, with a cfgFrames of 0 loaded as 1. A write of 00 or 11 to an idle channel has no effect.
- R3: A frame-done strobe for an active channel whose count is above 1 lowers that count by one. A frame-done strobe for an idle channel, or one that names a different channel, changes nothing.
- R4: On an active channel whose count is above 1, a write of 00 makes it idle with count 0 on the next cycle. A write of the other buffer switches to it and reloads the count. A write of the current buffer or of 11 has no effect.
- R5: On an active channel whose count is 1, a write does not change the enable value or the count until that channel's frame-done strobe arrives.
- R6: A 00 written during the last frame makes the channel idle (count 0) when the frame completes, whatever the mode.
- R7: The other buffer written during the last frame is selected when the frame completes, with the count reloaded, whatever the mode.
- R8: With no last-frame write, or a write of the current buffer or 11, the mode decides at the completion of the last frame. Mode 00 (one-shot) makes the channel idle with count 0. Mode 01 (auto-switch) moves to the other buffer and reloads. Modes 10 and 11 (circular) keep the buffer and reload.
- R9: A write in the same cycle as the final frame-done strobe counts as a last-frame write and replaces any write held earlier in that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgFrames | input | CNT_W | Frame count loaded whenever a buffer becomes active |
| modeSel | input | 2*NUM_CH | End-of-buffer mode per channel, two bits each, channel 0 in the low bits |
| wrEn | input | 1 | Enable-field write strobe |
| wrCh | input | IDX_W | Channel addressed by the write |
| wrData | input | 2 | Enable value written |
| frameDone | input | 1 | Frame completion strobe |
| frameCh | input | IDX_W | Channel whose frame completed |
| enState | output | 2*NUM_CH | Current enable value per channel |
| frameLeft | output | CNT_W*NUM_CH | Frames left in the active buffer per channel |

## Verification
Every result of this block is registered once. A write or frame-done strobe presented before a clock edge shows up on enState and frameLeft just after that same edge, so the bench drives each stimulus on the falling edge and compares two nanoseconds after the following rising edge. A write held during the last frame is shown not to take effect in the cycle after it arrives, and then to take effect in the cycle after the frame-done strobe. The table vectors walk one channel through every priority case, and the directed tests then cover reset, channel isolation, a zero frame count and the spare mode code.

// File: rtl/pkt_seq_pkg.sv
package pkt_seq_pkg;

  typedef enum logic [1:0] {
    ENC_OFF = 2'b00,
    ENC_A   = 2'b01,
    ENC_B   = 2'b10,
    ENC_NOP = 2'b11
  } bufEnc_e;

  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'b00,
    MODE_SWAP    = 2'b01,
    MODE_LOOP    = 2'b10,
    MODE_LOOP_X  = 2'b11
  } endMode_e;

  // strobes from the channel control to the channel datapath
  typedef struct packed {
    logic       load;     // take newEn, reload or clear the counter
    logic [1:0] newEn;
    logic       dec;      // count one frame down
    logic       setPend;  // hold wrData until the last frame ends
    logic       clrPend;
  } ctrlStb_t;

endpackage

// File: rtl/pkt_seq_ctrl.sv
module pkt_seq_ctrl
  import pkt_seq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int IDX_W = 2,
  parameter int CH_ID = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrCh,
  input  logic [1:0]       wrData,
  input  logic             frameDone,
  input  logic [IDX_W-1:0] frameCh,
  input  logic [1:0]       mode,
  input  logic [1:0]       curEn,
  input  logic [CNT_W-1:0] curCnt,
  input  logic             pendValid,
  input  logic [1:0]       pendVal,
  output ctrlStb_t         stb
);

  logic       wrHere;
  logic       doneHere;
  logic       active;
  logic       lastFrame;
  logic [1:0] otherBuf;
  logic       effHas;
  logic [1:0] effVal;

  assign wrHere    = wrEn && (wrCh == IDX_W'(CH_ID));
  assign doneHere  = frameDone && (frameCh == IDX_W'(CH_ID));
  assign active    = (curEn == ENC_A) || (curEn == ENC_B);
  assign lastFrame = active && (curCnt == CNT_W'(1));
  assign otherBuf  = {curEn[0], curEn[1]};
  // a write in the completing cycle replaces one held earlier
  assign effHas    = wrHere || pendValid;
  assign effVal    = wrHere ? wrData : pendVal;

  always_comb begin
    stb = '0;
    if (!active) begin
      if (wrHere && (wrData == ENC_A || wrData == ENC_B)) begin
        stb.load  = 1'b1;
        stb.newEn = wrData;
      end
    end else if (!lastFrame) begin
      if (wrHere && wrData == ENC_OFF) begin
        stb.load  = 1'b1;
        stb.newEn = ENC_OFF;
      end else if (wrHere && wrData == otherBuf) begin
        stb.load  = 1'b1;
        stb.newEn = otherBuf;
      end else if (doneHere) begin
        stb.dec = 1'b1;
      end
    end else if (doneHere) begin
      stb.clrPend = 1'b1;
      stb.load    = 1'b1;
      if (effHas && effVal == ENC_OFF) begin
        stb.newEn = ENC_OFF;
      end else if (effHas && effVal == otherBuf) begin
        stb.newEn = otherBuf;
      end else begin
        unique case (mode)
          MODE_ONESHOT: stb.newEn = ENC_OFF;
          MODE_SWAP:    stb.newEn = otherBuf;
          default:      stb.newEn = curEn;
        endcase
      end
    end else if (wrHere) begin
      stb.setPend = 1'b1;
    end
  end

  // R3
  count_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneHere && active && curCnt > CNT_W'(1) && !wrHere) |=> (curCnt == $past(curCnt) - CNT_W'(1)));

  // R5
  last_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastFrame && !doneHere) |=> ($stable(curEn) && $stable(curCnt)));

  // R8
  oneshot_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastFrame && doneHere && mode == MODE_ONESHOT && !pendValid && !wrHere) |=> (curEn == ENC_OFF));

endmodule

// File: rtl/pkt_seq_dpath.sv
module pkt_seq_dpath
  import pkt_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [1:0]       wrData,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [1:0]       curEn,
  output logic [CNT_W-1:0] curCnt,
  output logic             pendValid,
  output logic [1:0]       pendVal
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curEn  <= ENC_OFF;
      curCnt <= '0;
    end else if (stb.load) begin
      curEn  <= stb.newEn;
      curCnt <= (stb.newEn == ENC_OFF) ? '0 : reloadVal;
    end else if (stb.dec) begin
      curCnt <= curCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendVal   <= ENC_OFF;
    end else if (stb.clrPend) begin
      pendValid <= 1'b0;
    end else if (stb.setPend) begin
      pendValid <= 1'b1;
      pendVal   <= wrData;
    end
  end

  // R2
  enc_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    curEn != ENC_NOP);

  // R4
  idle_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curEn == ENC_OFF) == (curCnt == '0));

endmodule

// File: rtl/pkt_buf_sequencer.sv
module pkt_buf_sequencer
  import pkt_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [CNT_W-1:0]        cfgFrames,
  input  logic [2*NUM_CH-1:0]     modeSel,
  input  logic                    wrEn,
  input  logic [IDX_W-1:0]        wrCh,
  input  logic [1:0]              wrData,
  input  logic                    frameDone,
  input  logic [IDX_W-1:0]        frameCh,
  output logic [2*NUM_CH-1:0]     enState,
  output logic [CNT_W*NUM_CH-1:0] frameLeft
);

  logic [CNT_W-1:0] reloadVal;
  assign reloadVal = (cfgFrames == '0) ? CNT_W'(1) : cfgFrames;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    ctrlStb_t         stb;
    logic [1:0]       curEn;
    logic [CNT_W-1:0] curCnt;
    logic             pendValid;
    logic [1:0]       pendVal;

    pkt_seq_ctrl #(.CNT_W(CNT_W), .IDX_W(IDX_W), .CH_ID(ch)) ctrl_i (
      .clk       (clk),
      .rstN      (rstN),
      .wrEn      (wrEn),
      .wrCh      (wrCh),
      .wrData    (wrData),
      .frameDone (frameDone),
      .frameCh   (frameCh),
      .mode      (modeSel[2*ch +: 2]),
      .curEn     (curEn),
      .curCnt    (curCnt),
      .pendValid (pendValid),
      .pendVal   (pendVal),
      .stb       (stb)
    );

    pkt_seq_dpath #(.CNT_W(CNT_W)) dpath_i (
      .clk       (clk),
      .rstN      (rstN),
      .stb       (stb),
      .wrData    (wrData),
      .reloadVal (reloadVal),
      .curEn     (curEn),
      .curCnt    (curCnt),
      .pendValid (pendValid),
      .pendVal   (pendVal)
    );

    assign enState[2*ch +: 2]         = curEn;
    assign frameLeft[CNT_W*ch +: CNT_W] = curCnt;
  end

endmodule

// File: tb/pkt_buf_sequencer_tb_top.sv
`timescale 1ns/1ps
module pkt_buf_sequencer_tb_top;

  localparam int NUM_CH = 4;
  localparam int CNT_W  = 8;
  localparam int IDX_W  = 2;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic [CNT_W-1:0]        cfgFrames = 8'd3;
  logic [2*NUM_CH-1:0]     modeSel = '0;
  logic                    wrEn = 1'b0;
  logic [IDX_W-1:0]        wrCh = '0;
  logic [1:0]              wrData = '0;
  logic                    frameDone = 1'b0;
  logic [IDX_W-1:0]        frameCh = '0;
  logic [2*NUM_CH-1:0]     enState;
  logic [CNT_W*NUM_CH-1:0] frameLeft;

  int applied = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  pkt_buf_sequencer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .cfgFrames(cfgFrames), .modeSel(modeSel),
    .wrEn(wrEn), .wrCh(wrCh), .wrData(wrData),
    .frameDone(frameDone), .frameCh(frameCh),
    .enState(enState), .frameLeft(frameLeft)
  );

  // op: 0 idle, 1 write, 2 frame done, 3 write and frame done together
  typedef struct packed {
    logic [1:0] op;
    logic [1:0] data;
    logic [1:0] mode;
    logic [1:0] expEn;
    logic [7:0] expCnt;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 2'b01, 2'd2, 2'b01, 8'd3, 4'd2},  // R2 activate A
    '{2'd2, 2'b00, 2'd2, 2'b01, 8'd2, 4'd3},  // R3
    '{2'd2, 2'b00, 2'd2, 2'b01, 8'd1, 4'd3},  // R3
    '{2'd1, 2'b10, 2'd2, 2'b01, 8'd1, 4'd5},  // R5 held
    '{2'd2, 2'b00, 2'd2, 2'b10, 8'd3, 4'd7},  // R7 switch wins over circular
    '{2'd2, 2'b00, 2'd2, 2'b10, 8'd2, 4'd3},
    '{2'd2, 2'b00, 2'd2, 2'b10, 8'd1, 4'd3},
    '{2'd2, 2'b00, 2'd2, 2'b10, 8'd3, 4'd8},  // R8 circular
    '{2'd2, 2'b00, 2'd1, 2'b10, 8'd2, 4'd3},
    '{2'd2, 2'b00, 2'd1, 2'b10, 8'd1, 4'd3},
    '{2'd1, 2'b10, 2'd1, 2'b10, 8'd1, 4'd5},  // R5 same value held
    '{2'd2, 2'b00, 2'd1, 2'b01, 8'd3, 4'd8},  // R8 auto-switch decides
    '{2'd2, 2'b00, 2'd1, 2'b01, 8'd2, 4'd3},
    '{2'd2, 2'b00, 2'd1, 2'b01, 8'd1, 4'd3},
    '{2'd1, 2'b00, 2'd1, 2'b01, 8'd1, 4'd5},  // R5 disable held
    '{2'd2, 2'b00, 2'd1, 2'b00, 8'd0, 4'd6},  // R6 disable wins
    '{2'd2, 2'b00, 2'd1, 2'b00, 8'd0, 4'd3},  // R3 idle ignores done
    '{2'd1, 2'b10, 2'd1, 2'b10, 8'd3, 4'd2},  // R2 activate B
    '{2'd1, 2'b01, 2'd1, 2'b01, 8'd3, 4'd4},  // R4 immediate switch
    '{2'd2, 2'b00, 2'd0, 2'b01, 8'd2, 4'd3},
    '{2'd1, 2'b11, 2'd0, 2'b01, 8'd2, 4'd4},  // R4 11 ignored
    '{2'd2, 2'b00, 2'd0, 2'b01, 8'd1, 4'd3},
    '{2'd2, 2'b00, 2'd0, 2'b00, 8'd0, 4'd8},  // R8 one-shot
    '{2'd1, 2'b01, 2'd0, 2'b01, 8'd3, 4'd2},
    '{2'd2, 2'b00, 2'd0, 2'b01, 8'd2, 4'd3},
    '{2'd2, 2'b00, 2'd0, 2'b01, 8'd1, 4'd3},
    '{2'd3, 2'b10, 2'd0, 2'b10, 8'd3, 4'd9},  // R9 same-cycle switch
    '{2'd1, 2'b00, 2'd0, 2'b00, 8'd0, 4'd4},  // R4 immediate disable
    '{2'd1, 2'b01, 2'd0, 2'b01, 8'd3, 4'd2},
    '{2'd2, 2'b00, 2'd0, 2'b01, 8'd2, 4'd3},
    '{2'd2, 2'b00, 2'd0, 2'b01, 8'd1, 4'd3},
    '{2'd3, 2'b01, 2'd0, 2'b00, 8'd0, 4'd8},  // R8 same value, one-shot
    '{2'd1, 2'b10, 2'd2, 2'b10, 8'd3, 4'd2},
    '{2'd2, 2'b00, 2'd2, 2'b10, 8'd2, 4'd3},
    '{2'd2, 2'b00, 2'd2, 2'b10, 8'd1, 4'd3},
    '{2'd1, 2'b00, 2'd2, 2'b10, 8'd1, 4'd5},  // R5 pending disable
    '{2'd3, 2'b01, 2'd2, 2'b01, 8'd3, 4'd9}   // R9 override of held write
  };

  task automatic doOp(input logic [1:0] op, input int ch, input logic [1:0] data,
                      input logic [1:0] mode);
    @(negedge clk);
    modeSel   = {NUM_CH{mode}};
    wrEn      = op[0];
    frameDone = op[1];
    wrCh      = IDX_W'(ch);
    frameCh   = IDX_W'(ch);
    wrData    = data;
    @(posedge clk);
    #2;
    wrEn      = 1'b0;
    frameDone = 1'b0;
  endtask

  task automatic checkCh(input string tag, input int ch, input logic [1:0] expEn,
                         input logic [7:0] expCnt);
    logic [1:0] gotEn;
    logic [7:0] gotCnt;
    gotEn  = enState[2*ch +: 2];
    gotCnt = frameLeft[CNT_W*ch +: CNT_W];
    applied++;
    if (gotEn !== expEn || gotCnt !== expCnt) begin
      miscompares++;
      $display("FAIL %s ch%0d: got en=%b cnt=%0d, expected en=%b cnt=%0d",
               tag, ch, gotEn, gotCnt, expEn, expCnt);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state on every channel
    for (int c = 0; c < NUM_CH; c++) checkCh("R1 reset", c, 2'b00, 8'd0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      doOp(VECS[i].op, 1, VECS[i].data, VECS[i].mode);
      checkCh($sformatf("R%0d vector %0d", VECS[i].req, i), 1, VECS[i].expEn, VECS[i].expCnt);
    end

    // R3 frame done for another, idle channel leaves channel 1 alone
    doOp(2'd2, 2, 2'b00, 2'd2);
    checkCh("R3 other channel", 1, 2'b01, 8'd3);
    checkCh("R3 idle channel", 2, 2'b00, 8'd0);

    // R2 zero frame count loads as one
    cfgFrames = 8'd0;
    doOp(2'd1, 0, 2'b01, 2'd3);
    checkCh("R2 zero count", 0, 2'b01, 8'd1);

    // R8 spare mode code behaves as circular
    doOp(2'd2, 0, 2'b00, 2'd3);
    checkCh("R8 mode 11", 0, 2'b01, 8'd1);

    // R2 writing 11 to an idle channel does nothing
    doOp(2'd1, 3, 2'b11, 2'd0);
    checkCh("R2 idle 11", 3, 2'b00, 8'd0);

    // R2 writing 00 to an idle channel does nothing
    doOp(2'd1, 3, 2'b00, 2'd0);
    checkCh("R2 idle 00", 3, 2'b00, 8'd0);

    // R1 reset in mid-run clears all channels
    @(negedge clk);
    rstN = 1'b0;
    #2;
    for (int c = 0; c < NUM_CH; c++) checkCh("R1 mid reset", c, 2'b00, 8'd0);
    @(negedge clk);
    rstN = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule